// File: doc/BRIEF.md
# Direct Digital Synthesis Core with Four-Shape Waveform Bank

This block produces a stream of waveform samples at a programmable frequency. The requested frequency is given in hertz. Hardware converts it into a phase increment for the system clock. The increment is added to a phase register on every clock. The top bits of that phase select a point within one period of the waveform.

One shared sample memory holds four waveform shapes. Each shape has its own region, and the region is picked by a waveform-select input. The sample read from memory is then multiplied by a small amplitude factor before it leaves the block.

The block is meant to sit behind control logic that owns the user settings: shape, amplitude and frequency. Those settings may change at any time. A change of shape keeps the running phase, so the output continues from the same point in the period. The clock rate assumed for the conversion is a parameter, 50 MHz by default.

Top module: `dds_wavegen`

## Requirements
- R1: The tuning word is registered one clock after the frequency input and equals floor(freq_hz × 2^32 / 50,000,000). The product is formed at a width of at least 64 bits, so no input value overflows it.
- R2: The 32-bit phase register adds the tuning word on every clock and wraps modulo 2^32. The sawtooth output therefore repeats every floor or ceil of 2^32 / word clocks.
- R3: The memory address is the 2-bit waveform select in bits 9:8 and phase bits 31:24 in bits 7:0. Changing the select never resets the phase register.
- R4: The memory read is synchronous. Data for the address presented before a clock edge appears after that edge.
- R5: Region 0 holds a parabolic sine. With x = p mod 128 and q = min(x·(128−x)/32, 127), the sample is 128+q for p<128 and 128−q otherwise. Region 1 is a square wave: 255 for p<128, else 0. Region 2 is a triangle: 2p for p<128, else 2·(255−p). Region 3 is a rising ramp equal to p.
- R6: The output is a register holding sample × (amp_code + 1), so the scale factors are 1, 2, 3 and 4. An amp_code of 0 keeps the output below 256.
- R7: While reset is low at a clock edge, the tuning word, the phase register, the memory data register and the output are cleared to 0.
- R8: An amplitude change reaches the output one clock later. A waveform-select change reaches the output two clocks later, and the output still shows the old shape after the first of those clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wave_sel | input | 2 | Waveform region: 0 sine, 1 square, 2 triangle, 3 ramp |
| amp_code | input | 2 | Amplitude code; the scale factor is amp_code + 1 |
| freq_hz | input | 20 | Requested output frequency in hertz |
| sample_out | output | 10 | Scaled output sample, unsigned |

## Verification
A new frequency is due at the output four clocks after it is applied, one for each of the tuning register, the phase register, the memory data register and the output register. A new shape is due two clocks after it is applied, and a new amplitude one clock after.

The bench drives its inputs on the falling edge. It advances a behavioural model by one step on each rising edge, and compares the model against the output on the following falling edge, so every latency is counted exactly. Directed checks with a frozen phase sample the output one and two edges after a change. Period checks count the clocks between sawtooth wraps at several frequencies.

// File: rtl/dds_pkg.sv
// Package: shared constants and types for the DDS core.
// Assumes the waveform regions are numbered in the order listed below.
package dds_pkg;

    localparam int DEFAULT_CLK_HZ = 50_000_000;

    // Waveform regions of the shared sample memory, in address order.
    typedef enum logic [1:0] {
        WAVE_SINE   = 2'd0,
        WAVE_SQUARE = 2'd1,
        WAVE_TRI    = 2'd2,
        WAVE_RAMP   = 2'd3
    } wave_kind_e;

endpackage

// File: rtl/dds_tuning.sv
// Module: dds_tuning
// Converts a frequency in hertz into a phase increment for a clock of CLK_HZ.
// Assumes CLK_HZ is a constant, so the divide reduces to constant-divisor logic.
module dds_tuning #(
    parameter int CLK_HZ  = 50_000_000,
    parameter int FREQ_W  = 20,
    parameter int PHASE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FREQ_W-1:0]  freq_hz,
    output logic [PHASE_W-1:0] tune_word
);
    localparam int PROD_W = (FREQ_W + PHASE_W > 64) ? (FREQ_W + PHASE_W) : 64;

    logic [PROD_W-1:0] scaled;
    logic [PROD_W-1:0] quotient;

    // Widen the frequency and multiply it by 2^PHASE_W before dividing.
    always_comb begin
        scaled   = PROD_W'(freq_hz) << PHASE_W;
        quotient = scaled / PROD_W'(CLK_HZ);
    end

    // Register the truncated increment.
    always_ff @(posedge clk) begin
        if (!rst_n) tune_word <= '0;
        else        tune_word <= PHASE_W'(quotient);
    end
endmodule

// File: rtl/dds_phase_acc.sv
// Module: dds_phase_acc
// Adds the tuning word to the phase register every clock and exposes its top bits.
// Assumes wrap-around modulo 2^PHASE_W is the intended behaviour.
module dds_phase_acc #(
    parameter int PHASE_W = 32,
    parameter int OFFS_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] tune_word,
    output logic [PHASE_W-1:0] phase,
    output logic [OFFS_W-1:0]  phase_offs
);
    // Accumulate phase.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= '0;
        else        phase <= phase + tune_word;
    end

    // The most significant bits index one period of the waveform.
    assign phase_offs = phase[PHASE_W-1 -: OFFS_W];
endmodule

// File: rtl/dds_wave_rom.sv
// Module: dds_wave_rom
// Sample memory with one region per waveform and a registered read port.
// Contents are computed at elaboration; the default size is 1024 x 8.
module dds_wave_rom
    import dds_pkg::*;
#(
    parameter int SEL_W    = 2,
    parameter int OFFS_W   = 8,
    parameter int SAMPLE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SEL_W+OFFS_W-1:0] addr,
    output logic [SAMPLE_W-1:0]     rd_data
);
    localparam int ADDR_W = SEL_W + OFFS_W;
    localparam int DEPTH  = 2 ** ADDR_W;
    localparam int REGION = 2 ** OFFS_W;
    localparam int HALF   = REGION / 2;
    localparam int FULL   = 2 ** SAMPLE_W - 1;
    localparam int MID    = 2 ** (SAMPLE_W - 1);

    logic [SAMPLE_W-1:0] mem [DEPTH];

    // Computes one sample of the given region at phase position pos.
    function automatic logic [SAMPLE_W-1:0] wave_point(input int region, input int pos);
        int x;
        int bump;
        int fold;
        int val;
        x    = pos % HALF;
        bump = (x * (HALF - x) * 4 * MID) / (HALF * HALF);
        if (bump > MID - 1) bump = MID - 1;
        fold = (pos < HALF) ? pos : (2 * HALF - 1 - pos);
        case (wave_kind_e'(region[1:0]))
            WAVE_SINE:   val = (pos < HALF) ? (MID + bump) : (MID - bump);
            WAVE_SQUARE: val = (pos < HALF) ? FULL : 0;
            WAVE_TRI:    val = (fold * 2 * (FULL + 1)) / REGION;
            default:     val = (pos * (FULL + 1)) / REGION;
        endcase
        return SAMPLE_W'(val);
    endfunction

    // Fill every memory word from its region and phase position.
    for (genvar g = 0; g < DEPTH; g++) begin : g_fill
        assign mem[g] = wave_point(g / REGION, g % REGION);
    end

    // Synchronous read: the address is sampled on the edge.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= mem[addr];
    end
endmodule

// File: rtl/dds_amp_scale.sv
// Module: dds_amp_scale
// Multiplies a sample by (amplitude code + 1) and registers the result.
// Assumes the output width covers the largest product.
module dds_amp_scale #(
    parameter int SAMPLE_W = 8,
    parameter int AMP_W    = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [SAMPLE_W-1:0]       sample,
    input  logic [AMP_W-1:0]          amp_code,
    output logic [SAMPLE_W+AMP_W-1:0] scaled
);
    localparam int OUT_W = SAMPLE_W + AMP_W;

    logic [AMP_W:0] factor;

    // The scale factor runs from 1 to 2^AMP_W.
    assign factor = {1'b0, amp_code} + 1'b1;

    // Register the scaled sample.
    always_ff @(posedge clk) begin
        if (!rst_n) scaled <= '0;
        else        scaled <= OUT_W'(sample) * OUT_W'(factor);
    end
endmodule

// File: rtl/dds_wavegen.sv
// Module: dds_wavegen (top)
// DDS core: converts hertz to a tuning word, accumulates phase, reads a shaped
// sample from a shared memory region and scales it.
// Assumes the inputs are synchronous to clk.
module dds_wavegen #(
    parameter int CLK_HZ   = 50_000_000,
    parameter int FREQ_W   = 20,
    parameter int PHASE_W  = 32,
    parameter int OFFS_W   = 8,
    parameter int SEL_W    = 2,
    parameter int SAMPLE_W = 8,
    parameter int AMP_W    = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [SEL_W-1:0]          wave_sel,
    input  logic [AMP_W-1:0]          amp_code,
    input  logic [FREQ_W-1:0]         freq_hz,
    output logic [SAMPLE_W+AMP_W-1:0] sample_out
);
    localparam int ADDR_W = SEL_W + OFFS_W;

    logic [PHASE_W-1:0]  tune_word;
    logic [PHASE_W-1:0]  phase_acc;
    logic [OFFS_W-1:0]   phase_offs;
    logic [ADDR_W-1:0]   rom_addr;
    logic [SAMPLE_W-1:0] rom_q;

    dds_tuning #(
        .CLK_HZ (CLK_HZ),
        .FREQ_W (FREQ_W),
        .PHASE_W(PHASE_W)
    ) u_tuning (
        .clk      (clk),
        .rst_n    (rst_n),
        .freq_hz  (freq_hz),
        .tune_word(tune_word)
    );

    dds_phase_acc #(
        .PHASE_W(PHASE_W),
        .OFFS_W (OFFS_W)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .tune_word (tune_word),
        .phase     (phase_acc),
        .phase_offs(phase_offs)
    );

    // The region base comes from the select; the offset comes from the phase.
    assign rom_addr = {wave_sel, phase_offs};

    dds_wave_rom #(
        .SEL_W   (SEL_W),
        .OFFS_W  (OFFS_W),
        .SAMPLE_W(SAMPLE_W)
    ) u_rom (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (rom_addr),
        .rd_data(rom_q)
    );

    dds_amp_scale #(
        .SAMPLE_W(SAMPLE_W),
        .AMP_W   (AMP_W)
    ) u_scale (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample  (rom_q),
        .amp_code(amp_code),
        .scaled  (sample_out)
    );
endmodule

// File: rtl/dds_wavegen_chk.sv
// Module: dds_wavegen_chk
// Assertion checker bound into dds_wavegen. It observes the ports and the
// internal stage outputs.
module dds_wavegen_chk #(
    parameter int FREQ_W   = 20,
    parameter int PHASE_W  = 32,
    parameter int OFFS_W   = 8,
    parameter int SEL_W    = 2,
    parameter int SAMPLE_W = 8,
    parameter int AMP_W    = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [SEL_W-1:0]          wave_sel,
    input logic [AMP_W-1:0]          amp_code,
    input logic [FREQ_W-1:0]         freq_hz,
    input logic [SAMPLE_W+AMP_W-1:0] sample_out,
    input logic [PHASE_W-1:0]        tune_word,
    input logic [PHASE_W-1:0]        phase_acc,
    input logic [SAMPLE_W-1:0]       rom_q
);
    localparam int OUT_W = SAMPLE_W + AMP_W;

    logic armed = 1'b0;

    // Becomes true once the first edge has passed.
    always_ff @(posedge clk) armed <= 1'b1;

    // R7
    reset_clear_chk: assert property (@(posedge clk) disable iff (!armed)
        !rst_n |=> (sample_out == '0 && phase_acc == '0 && tune_word == '0));

    // R1
    zero_freq_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(freq_hz) == '0) |-> tune_word == '0);

    // R2
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> phase_acc == $past(phase_acc) + $past(tune_word));

    // R4
    ramp_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wave_sel) == '1)
            |-> rom_q == $past(phase_acc[PHASE_W-1 -: OFFS_W]));

    // R6
    zero_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rom_q) == '0) |-> sample_out == '0);

    // R6
    unity_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(amp_code) == '0)
            |-> sample_out[OUT_W-1:SAMPLE_W] == '0);
endmodule

bind dds_wavegen dds_wavegen_chk #(
    .FREQ_W  (FREQ_W),
    .PHASE_W (PHASE_W),
    .OFFS_W  (OFFS_W),
    .SEL_W   (SEL_W),
    .SAMPLE_W(SAMPLE_W),
    .AMP_W   (AMP_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wave_sel  (wave_sel),
    .amp_code  (amp_code),
    .freq_hz   (freq_hz),
    .sample_out(sample_out),
    .tune_word (tune_word),
    .phase_acc (phase_acc),
    .rom_q     (rom_q)
);

// File: tb/dds_wavegen_tb.sv
`timescale 1ns/1ps
module dds_wavegen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] wave_sel = 2'd0;
    logic [1:0] amp_code = 2'd0;
    logic [19:0] freq_hz = 20'd0;
    logic [9:0] sample_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit cmp_on = 1'b0;

    longint unsigned m_word = 0, m_acc = 0, m_rom = 0, m_out = 0;

    always #2.5 clk = ~clk;

    dds_wavegen u_dut (
        .clk(clk), .rst_n(rst_n), .wave_sel(wave_sel),
        .amp_code(amp_code), .freq_hz(freq_hz), .sample_out(sample_out)
    );

    // Expected sample for a region and phase position, written from R5.
    function automatic int ref_tbl(input int region, input int p);
        int x, q;
        if (region == 0) begin
            x = p % 128;
            q = (x * (128 - x)) / 32;
            if (q > 127) q = 127;
            return (p < 128) ? 128 + q : 128 - q;
        end else if (region == 1) begin
            return (p < 128) ? 255 : 0;
        end else if (region == 2) begin
            return (p < 128) ? 2 * p : 2 * (255 - p);
        end
        return p;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Behavioural model: one step per rising edge.
    always @(posedge clk) begin
        longint unsigned n_out, n_rom, n_acc, n_word;
        cycles++;
        if (!rst_n) begin
            m_word = 0; m_acc = 0; m_rom = 0; m_out = 0;
        end else begin
            n_out  = m_rom * (amp_code + 1);
            n_rom  = ref_tbl(int'(wave_sel), int'((m_acc >> 24) & 255));
            n_acc  = (m_acc + m_word) & 64'hFFFF_FFFF;
            n_word = (longint'(freq_hz) << 32) / 50_000_000;
            m_out = n_out; m_rom = n_rom; m_acc = n_acc; m_word = n_word;
        end
        cmp_on = 1'b1;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog (R2 run did not end) actual=%0d expected=%0d", cycles, 100000);
            report();
        end
    end

    // Compare against the model on every falling edge.
    always @(negedge clk) begin
        if (cmp_on)
            chk(sample_out == 10'(m_out), "R1 R2 R3 R4 R5 R6 R7 model compare",
                sample_out, m_out);
    end

    task automatic nclk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // R2: clocks between ramp wraps must equal floor or ceil of 2^32/word.
    task automatic period_check(input int f);
        longint unsigned w, lo;
        int n;
        logic [9:0] prev;
        freq_hz = 20'(f); wave_sel = 2'd3; amp_code = 2'd0;
        nclk(8);
        prev = sample_out;
        do begin prev = sample_out; nclk(1); end while (sample_out >= prev);
        n = 0;
        do begin prev = sample_out; nclk(1); n++; end while (sample_out >= prev);
        w  = (longint'(f) << 32) / 50_000_000;
        lo = (64'd1 << 32) / w;
        chk(n == int'(lo) || n == int'(lo) + 1, "R2 ramp period", n, lo);
    endtask

    initial begin
        nclk(4);
        // R7: the output is cleared during reset.
        chk(sample_out == 10'd0, "R7 reset output", sample_out, 0);

        // Frozen phase at 0: square region gives 255 at p=0.
        wave_sel = 2'd1; amp_code = 2'd0; freq_hz = 20'd0;
        rst_n = 1'b1;
        nclk(3);
        chk(sample_out == 10'd255, "R5 R6 square x1", sample_out, 255);
        for (int k = 1; k < 4; k++) begin
            amp_code = 2'(k);
            nclk(1);
            chk(sample_out == 10'(255 * (k + 1)), "R6 R8 amplitude one clock", sample_out, 255 * (k + 1));
        end
        // R8: a select change shows after two edges, not after one.
        wave_sel = 2'd2;
        nclk(1);
        chk(sample_out == 10'd1020, "R8 select not yet visible", sample_out, 1020);
        nclk(1);
        chk(sample_out == 10'd0, "R8 R3 triangle at p=0", sample_out, 0);
        wave_sel = 2'd0;
        nclk(2);
        chk(sample_out == 10'd512, "R5 sine midpoint x4", sample_out, 512);

        // Running phase while the shape and amplitude change (R3: phase kept).
        freq_hz = 20'd123_456;
        for (int i = 0; i < 600; i++) begin
            if (i % 75 == 0) wave_sel = wave_sel + 2'd1;
            if (i % 110 == 0) amp_code = amp_code + 2'd1;
            nclk(1);
        end

        period_check(1_000_000);
        period_check(500_000);
        period_check(195_000);

        // Reset in the middle of a run.
        rst_n = 1'b0;
        nclk(2);
        chk(sample_out == 10'd0, "R7 mid-run reset", sample_out, 0);
        rst_n = 1'b1;
        freq_hz = 20'hFFFFF; wave_sel = 2'd0; amp_code = 2'd3;
        nclk(300);
        report();
    end
endmodule